// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers a set of external request pins and turns each into a latched request towards an interrupt controller or a data-transfer engine. Every channel has its own detection setting, which is one of low level, high level, rising edge or falling edge. It also has an enable bit and a pending cause flag. Once the selected condition is seen, the cause flag latches and stays set until software clears it, even when the pin has since returned to idle. The flag reaches the outputs only through the channel's enable bit. A per-channel routing bit sends it either to the interrupt request vector or to the transfer request vector.

Every pin passes through a two-flop synchroniser. Edge detection also needs the new level to be held for a programmable minimum number of cycles. A pulse at least as long as the limit is detected, and a shorter one is ignored.

When the transfer engine acknowledges a channel, the cause is cleared and detection on that channel is masked for a fixed window. The external peripheral is expected to withdraw its request within that window. If the request is still present once the window has passed, the cause is raised again, so a level request that was not withdrawn counts as a new request.

Software programs the block through a small word-wide register bus. Enable bits and cause bits share one word, so a single write can clear causes and enable channels together.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, all enable, routing and cause bits are 0, every detection field reads 2'b10 (rising edge), and both request outputs are 0.
- R2: Detection code 2'b00 sets the cause while the synchronised pin is low, and code 2'b01 sets it while the pin is high. The cause is set on the third clock edge after the pin changes, and the request output follows one edge later.
- R3: A set cause stays set after the pin goes inactive. Writing 0 to its bit in the control word (bits NCH-1:0 at address 0) clears it, and writing 1 leaves it unchanged.
- R4: Each request output bit is the cause ANDed with the enable bit (control word bits 2*NCH-1:NCH), registered one cycle. The output goes to `int_req_o` when the routing bit (address 2) is 0 and to `xfer_req_o` when it is 1, never to both.
- R5: Codes 2'b10 (rising) and 2'b11 (falling) set the cause only after the synchronised pin has held its new level for MIN_PW consecutive cycles. A pulse of MIN_PW-1 cycles sets nothing.
- R6: When software clears a cause in the same cycle that a new detection occurs, the detection wins and the cause stays set.
- R7: One write to address 0 clears the selected causes and loads all enable bits in the same cycle.
- R8: An acknowledge pulse on `xfer_ack_i` clears that channel's cause and masks detection in the acknowledge cycle and the next XFER_WIN cycles. A level request still present after that sets the cause again, and a request withdrawn in time leaves it clear.
- R9: Address 1 holds the 2-bit detection fields (channel i at bits 2i+1:2i). Address 2 holds the routing bits. Both read back what was written, and address 3 reads 0. Read data is registered one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin_i | input | NCH | Asynchronous external request pins |
| xfer_ack_i | input | NCH | Per-channel transfer acknowledge pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 2*NCH | Register write data |
| reg_rdata_o | output | 2*NCH | Registered read data |
| int_req_o | output | NCH | Gated requests routed to the interrupt controller |
| xfer_req_o | output | NCH | Gated requests routed to the transfer engine |

## Verification
The bench builds the block with NCH=8, MIN_PW=3 and XFER_WIN=3. Eight channels are few enough to sweep every channel through all four detection codes. For each code the bench checks the exact latency, the hold-after-release behaviour and the clear. With MIN_PW=3, a two-cycle pulse must be rejected while a three-cycle pulse is accepted. With a three-cycle window, the bench can place a withdrawn request and a held request on either side of the mask boundary and predict the cycle in which the transfer request comes back.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_LVL  = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
  import xirq_pkg::*;
#(
  parameter int MIN_PW   = 2,
  parameter int XFER_WIN = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din_i,
  input  det_mode_e mode_i,
  input  logic      keep_i,
  input  logic      ack_i,
  output logic      cause_o
);
  localparam int CW = $clog2(MIN_PW + 1);
  localparam int WW = $clog2(XFER_WIN + 1);

  logic          filt_q;
  logic [CW-1:0] run_q;
  logic [WW-1:0] win_q;
  logic          cause_q;
  logic          accept;
  logic          hit;
  logic          masked;

  // a level change is accepted after MIN_PW consecutive differing samples
  assign accept = (din_i != filt_q) && (run_q == CW'(MIN_PW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (din_i == filt_q) begin
      run_q <= '0;
    end else if (accept) begin
      filt_q <= din_i;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  always_comb begin
    unique case (mode_i)
      DET_LOW:  hit = ~din_i;
      DET_HIGH: hit = din_i;
      DET_RISE: hit = accept & din_i;
      DET_FALL: hit = accept & ~din_i;
      default:  hit = 1'b0;
    endcase
  end

  assign masked = ack_i | (win_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (ack_i) begin
      win_q <= WW'(XFER_WIN);
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= 1'b0;
    end else begin
      cause_q <= (hit & ~masked) | (cause_q & keep_i & ~ack_i);
    end
  end

  assign cause_o = cause_q;

  // R3
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_q && keep_i && !ack_i) |=> cause_q);

  // R8
  win_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((win_q != '0) && !cause_q) |=> !cause_q);

  // R5
  filt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (filt_q == $past(din_i)));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int MIN_PW   = 2,
  parameter int XFER_WIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   req_pin_i,
  input  logic [NCH-1:0]   xfer_ack_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [2*NCH-1:0] reg_wdata_i,
  output logic [2*NCH-1:0] reg_rdata_o,
  output logic [NCH-1:0]   int_req_o,
  output logic [NCH-1:0]   xfer_req_o
);
  localparam int DW = 2 * NCH;

  logic [NCH-1:0] pin_sync;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] route_q;
  logic [DW-1:0]  lvl_q;
  logic [NCH-1:0] cause;
  logic [NCH-1:0] keep;
  logic           ctrl_wr;

  xirq_sync #(.W(NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (req_pin_i),
    .q_o (pin_sync)
  );

  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL);
  assign keep    = ctrl_wr ? reg_wdata_i[NCH-1:0] : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '0;
      lvl_q   <= {NCH{DET_RISE}};
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        REG_CTRL: en_q    <= reg_wdata_i[DW-1:NCH];
        REG_LVL:  lvl_q   <= reg_wdata_i;
        REG_MODE: route_q <= reg_wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    xirq_chan #(.MIN_PW(MIN_PW), .XFER_WIN(XFER_WIN)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .din_i   (pin_sync[i]),
      .mode_i  (det_mode_e'(lvl_q[2*i +: 2])),
      .keep_i  (keep[i]),
      .ack_i   (xfer_ack_i[i]),
      .cause_o (cause[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      int_req_o   <= '0;
      xfer_req_o  <= '0;
    end else begin
      unique case (reg_addr_i)
        REG_CTRL: reg_rdata_o <= {en_q, cause};
        REG_LVL:  reg_rdata_o <= lvl_q;
        REG_MODE: reg_rdata_o <= {{NCH{1'b0}}, route_q};
        default:  reg_rdata_o <= '0;
      endcase
      int_req_o  <= cause & en_q & ~route_q;
      xfer_req_o <= cause & en_q & route_q;
    end
  end

  // R4
  route_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((int_req_o & xfer_req_o) == '0));

  // R4
  gate_en_chk: assert property (@(posedge clk) disable iff (rst)
    (((int_req_o | xfer_req_o) & ~$past(en_q)) == '0));
endmodule

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int PW  = 3;
  localparam int WIN = 3;
  localparam int DW  = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  ack = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  int_req;
  logic [N-1:0]  xfer_req;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl #(.NCH(N), .MIN_PW(PW), .XFER_WIN(WIN)) uut (
    .clk         (clk),
    .rst         (rst),
    .req_pin_i   (pins),
    .xfer_ack_i  (ack),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .int_req_o   (int_req),
    .xfer_req_o  (xfer_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    step(1);
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    @(negedge clk);
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk("R1 int", 32'(int_req), 0);
    chk("R1 xfer", 32'(xfer_req), 0);
    rd(2'd0, r); chk("R1 ctrl", 32'(r), 0);
    rd(2'd1, r); chk("R1 lvl", 32'(r), 32'hAAAA);
    rd(2'd2, r); chk("R1 route", 32'(r), 0);

    // sweep every channel through every detection code
    for (int ch = 0; ch < N; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic idle;
        logic [DW-1:0] lw;
        logic [N-1:0] bitv;
        bitv = N'(1) << ch;
        idle = (m == 0 || m == 3);
        lw = {N{2'b10}};
        lw[2*ch +: 2] = 2'(m);
        wr(2'd0, '0);
        pins[ch] = idle;
        wr(2'd1, lw);
        step(PW + 4);
        wr(2'd0, {bitv, {N{1'b0}}});
        step(1);
        chk("R4 enabled no cause", 32'(int_req), 0);
        if (m < 2) begin
          // R2 level detection latency
          pins[ch] = ~idle;
          step(3);
          chk("R2 level before latency", 32'(int_req), 0);
          step(1);
          chk("R2 level detected", 32'(int_req), 32'(bitv));
          pins[ch] = idle;
          step(5);
          chk("R3 held after release", 32'(int_req), 32'(bitv));
        end else begin
          // R5 short pulse rejected
          pins[ch] = ~idle;
          step(PW - 1);
          pins[ch] = idle;
          step(PW + 4);
          chk("R5 short pulse ignored", 32'(int_req), 0);
          pins[ch] = ~idle;
          step(PW + 2);
          chk("R5 edge before latency", 32'(int_req), 0);
          step(1);
          chk("R5 edge detected", 32'(int_req), 32'(bitv));
          pins[ch] = idle;
          step(PW + 3);
          chk("R3 edge cause held", 32'(int_req), 32'(bitv));
        end
        wr(2'd0, {bitv, ~bitv});
        step(1);
        chk("R3 cleared by zero", 32'(int_req), 0);
      end
      pins[ch] = 1'b0;
    end

    // R4 gating and routing, R3 write-one keeps
    wr(2'd0, '0);
    wr(2'd1, {N{2'b01}});
    pins = '1;
    step(5);
    chk("R4 disabled gate", 32'(int_req | xfer_req), 0);
    wr(2'd0, {8'hA5, 8'hFF});
    step(1);
    chk("R3 R4 keep and gate", 32'(int_req), 32'hA5);
    wr(2'd2, 16'h000F);
    step(1);
    chk("R4 route int", 32'(int_req), 32'hA0);
    chk("R4 route xfer", 32'(xfer_req), 32'h05);

    // R7 combined clear and enable
    pins = '0;
    step(4);
    wr(2'd0, {8'hFF, 8'h00});
    step(1);
    chk("R7 int cleared", 32'(int_req), 0);
    chk("R7 xfer cleared", 32'(xfer_req), 0);
    rd(2'd0, r);
    chk("R7 ctrl word", 32'(r), 32'hFF00);

    // R6 detection wins over clear
    wr(2'd2, '0);
    pins[1] = 1'b1;
    step(5);
    wr(2'd0, {8'hFF, 8'h00});
    step(1);
    chk("R6 detection wins", 32'(int_req), 32'h02);
    pins[1] = 1'b0;
    step(4);
    wr(2'd0, {8'hFF, 8'h00});

    // R8 held request comes back after the window
    wr(2'd2, 16'h0004);
    pins[2] = 1'b1;
    step(5);
    chk("R8 xfer raised", 32'(xfer_req), 32'h04);
    ack[2] = 1'b1;
    step(1);
    ack[2] = 1'b0;
    step(1);
    chk("R8 cleared by ack", 32'(xfer_req), 0);
    step(3);
    chk("R8 masked in window", 32'(xfer_req), 0);
    step(1);
    chk("R8 held request re-raised", 32'(xfer_req), 32'h04);
    // R8 withdrawn request stays clear
    ack[2] = 1'b1;
    step(1);
    ack[2] = 1'b0;
    pins[2] = 1'b0;
    step(6);
    chk("R8 withdrawn stays clear", 32'(xfer_req), 0);
    rd(2'd0, r);
    chk("R8 cause clear", 32'(r[2]), 0);

    // R9 readback
    wr(2'd1, 16'h1B6C);
    rd(2'd1, r); chk("R9 lvl", 32'(r), 32'h1B6C);
    wr(2'd2, 16'h003C);
    rd(2'd2, r); chk("R9 route", 32'(r), 32'h003C);
    rd(2'd3, r); chk("R9 unused", 32'(r), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule